// File: doc/BRIEF.md
# Dual Nibble-Lane Pixel Packer

This block takes two 4-bit lanes, one carrying luma and the other chroma, and rebuilds 16-bit YUV pixel words for a video encoder that consumes one word per pixel period. Each lane sends one byte as two nibbles, upper nibble first. A nibble is taken on a falling edge of that lane's strobe, and only while the lane's handshake line is high. When the handshake line drops, any half-received byte is discarded.

The block has two register stages. When both lanes hold a finished byte, the pair is packed into a first-stage word. The output register takes that word on the next pixel tick, which arrives at the pixel rate, and raises a one-cycle valid flag. If a tick comes with no word ready, the output keeps the last word and a sticky underrun flag is set. All logic runs on one fast clock. The lane strobes and the pixel tick arrive as level and pulse inputs that are already synchronous to that clock. A synchronous reset returns everything to idle.

Top module: `vyc_nibble_packer`

## Requirements
- R1: While reset is high, and after it, until a word is delivered, pix_word is 0, pix_valid is 0 and underrun is 0.
- R2: On each lane, the first nibble taken after the lane becomes idle forms bits 7:4 of that lane's byte. The second nibble forms bits 3:0.
- R3: The packed word carries the luma byte in bits 15:8 and the chroma byte in bits 7:0.
- R4: A nibble is taken only on a high-to-low transition of the lane strobe while the lane acknowledge is 1. Strobe transitions while the acknowledge is 0 capture nothing.
- R5: An acknowledge value of 0 returns the lane to expecting an upper nibble, so a half-received byte is never packed.
- R6: A word is packed only when both lanes have completed a byte. A byte finished on one lane waits, and is paired with the next byte completed on the other lane.
- R7: On a cycle with pix_tick high and a packed word waiting, pix_word takes that word and pix_valid is 1 for exactly the next cycle.
- R8: On a cycle with pix_tick high and no packed word waiting, pix_word keeps its value, pix_valid stays 0 and underrun becomes 1. underrun then stays 1 until reset.
- R9: A synchronous reset clears both lane phases, both word stages and the underrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than both the lane strobes and the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| luma_nib | input | 4 | Luma lane nibble |
| luma_strobe | input | 1 | Luma lane strobe; a nibble is taken on its falling edge |
| luma_ack | input | 1 | Luma lane handshake; 0 aborts a partial byte |
| chroma_nib | input | 4 | Chroma lane nibble |
| chroma_strobe | input | 1 | Chroma lane strobe; a nibble is taken on its falling edge |
| chroma_ack | input | 1 | Chroma lane handshake; 0 aborts a partial byte |
| pix_tick | input | 1 | One-cycle pulse at the pixel rate |
| pix_word | output | 16 | Packed pixel: luma 15:8, chroma 7:0 |
| pix_valid | output | 1 | High for one cycle when pix_word takes a new word |
| underrun | output | 1 | Sticky flag: a pixel tick found no word waiting |

## Verification
The hardest case to reach is a lane that finishes its byte well before the other lane, followed by a pixel tick that falls between the two completions. The early byte has to stay parked, the tick has to report an underrun without disturbing the output, and the late byte has to pair with the parked one. The stimulus drives the luma lane alone, pulses the tick, and then drives the chroma lane alone. The expected word is the parked luma byte with the new chroma byte. A separate run sends an upper nibble, drops the acknowledge, and then sends a full byte, so the lane phase is tested only through the value of the word that comes out.

// File: rtl/vyc_pkg.sv
package vyc_pkg;
    localparam int NIB_W   = 4;
    localparam int BYTE_W  = 2 * NIB_W;
    localparam int LANES   = 2;
    localparam int PIX_W   = LANES * BYTE_W;
    localparam int LUMA_IX = 0;
    localparam int CHRO_IX = 1;

    typedef enum logic {
        PH_UPPER = 1'b0,
        PH_LOWER = 1'b1
    } nib_phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] luma;
        logic [BYTE_W-1:0] chroma;
    } pix_word_t;

    function automatic logic [BYTE_W-1:0] join_nibbles(
        input logic [NIB_W-1:0] upper,
        input logic [NIB_W-1:0] lower
    );
        return {upper, lower};
    endfunction
endpackage

// File: rtl/vyc_lane_capture.sv
module vyc_lane_capture
    import vyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  nib,
    input  logic              strobe,
    input  logic              ack,
    input  logic              take,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ready
);
    logic              strobe_q;
    logic              strobe_fall;
    nib_phase_e        phase;
    logic [NIB_W-1:0]  upper_q;
    logic [BYTE_W-1:0] byte_q;
    logic              ready_q;
    logic              finish;

    assign strobe_fall = strobe_q & ~strobe;
    assign finish      = ack & strobe_fall & (phase == PH_LOWER);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            phase    <= PH_UPPER;
            upper_q  <= '0;
            byte_q   <= '0;
            ready_q  <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (!ack) begin
                phase <= PH_UPPER;
            end else if (strobe_fall) begin
                if (phase == PH_UPPER) begin
                    upper_q <= nib;
                    phase   <= PH_LOWER;
                end else begin
                    byte_q <= join_nibbles(upper_q, nib);
                    phase  <= PH_UPPER;
                end
            end
            if (finish) begin
                ready_q <= 1'b1;
            end else if (take) begin
                ready_q <= 1'b0;
            end
        end
    end

    assign byte_o = byte_q;
    assign ready  = ready_q;
endmodule

// File: rtl/vyc_word_handoff.sv
module vyc_word_handoff
    import vyc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0]             lane_ready,
    input  logic [LANES-1:0][BYTE_W-1:0] lane_byte,
    input  logic                         tick,
    output logic                         take,
    output logic [PIX_W-1:0]             word_o,
    output logic                         valid_o,
    output logic                         underrun_o
);
    pix_word_t stage1_q;
    logic      stage1_full;
    pix_word_t stage2_q;
    logic      valid_q;
    logic      underrun_q;
    pix_word_t packed_w;

    assign take            = &lane_ready;
    assign packed_w.luma   = lane_byte[LUMA_IX];
    assign packed_w.chroma = lane_byte[CHRO_IX];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q    <= '0;
            stage1_full <= 1'b0;
        end else begin
            if (take) begin
                stage1_q <= packed_w;
            end
            stage1_full <= take | (stage1_full & ~tick);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage2_q   <= '0;
            valid_q    <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (tick) begin
                if (stage1_full) begin
                    stage2_q <= stage1_q;
                    valid_q  <= 1'b1;
                end else begin
                    underrun_q <= 1'b1;
                end
            end
        end
    end

    assign word_o     = stage2_q;
    assign valid_o    = valid_q;
    assign underrun_o = underrun_q;
endmodule

// File: rtl/vyc_nibble_packer.sv
module vyc_nibble_packer
    import vyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] luma_nib,
    input  logic             luma_strobe,
    input  logic             luma_ack,
    input  logic [NIB_W-1:0] chroma_nib,
    input  logic             chroma_strobe,
    input  logic             chroma_ack,
    input  logic             pix_tick,
    output logic [PIX_W-1:0] pix_word,
    output logic             pix_valid,
    output logic             underrun
);
    logic [LANES-1:0][NIB_W-1:0]  lane_nib;
    logic [LANES-1:0]             lane_strobe;
    logic [LANES-1:0]             lane_ack;
    logic [LANES-1:0][BYTE_W-1:0] lane_byte;
    logic [LANES-1:0]             lane_ready;
    logic                         take;

    assign lane_nib[LUMA_IX]    = luma_nib;
    assign lane_nib[CHRO_IX]    = chroma_nib;
    assign lane_strobe[LUMA_IX] = luma_strobe;
    assign lane_strobe[CHRO_IX] = chroma_strobe;
    assign lane_ack[LUMA_IX]    = luma_ack;
    assign lane_ack[CHRO_IX]    = chroma_ack;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vyc_lane_capture i_cap (
            .clk    (clk),
            .rst    (rst),
            .nib    (lane_nib[g]),
            .strobe (lane_strobe[g]),
            .ack    (lane_ack[g]),
            .take   (take),
            .byte_o (lane_byte[g]),
            .ready  (lane_ready[g])
        );
    end

    vyc_word_handoff i_hand (
        .clk        (clk),
        .rst        (rst),
        .lane_ready (lane_ready),
        .lane_byte  (lane_byte),
        .tick       (pix_tick),
        .take       (take),
        .word_o     (pix_word),
        .valid_o    (pix_valid),
        .underrun_o (underrun)
    );
endmodule

// File: rtl/vyc_packer_checker.sv
module vyc_packer_checker
    import vyc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pix_tick,
    input logic [PIX_W-1:0] pix_word,
    input logic             pix_valid,
    input logic             underrun
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pix_valid && !underrun && pix_word == '0));

    a_r7_valid_after_tick: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(pix_tick));

    a_r7_single_cycle_valid: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !$past(pix_tick)) |-> 1'b0);

    a_r8_hold_without_valid: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !$past(rst)) |-> $stable(pix_word));

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(underrun) && !$past(rst)) |-> underrun);

    a_r8_underrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> ($past(pix_tick) && !pix_valid));
endmodule

bind vyc_nibble_packer vyc_packer_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_tick  (pix_tick),
    .pix_word  (pix_word),
    .pix_valid (pix_valid),
    .underrun  (underrun)
);

// File: tb/test_vyc_nibble_packer.sv
module test_vyc_nibble_packer;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  luma_nib = '0;
    logic        luma_strobe = 1'b0;
    logic        luma_ack = 1'b0;
    logic [3:0]  chroma_nib = '0;
    logic        chroma_strobe = 1'b0;
    logic        chroma_ack = 1'b0;
    logic        pix_tick = 1'b0;
    logic [15:0] pix_word;
    logic        pix_valid;
    logic        underrun;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [15:0] last_word = '0;

    vyc_nibble_packer i_vyc_nibble_packer (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] y, input logic [7:0] c,
                        input logic use_y, input logic use_c, input logic ackv);
        for (int k = 0; k < 2; k++) begin
            luma_ack = ackv; chroma_ack = ackv;
            if (use_y) begin luma_nib = (k == 0) ? y[7:4] : y[3:0]; luma_strobe = 1'b1; end
            if (use_c) begin chroma_nib = (k == 0) ? c[7:4] : c[3:0]; chroma_strobe = 1'b1; end
            @(negedge clk);
            luma_strobe = 1'b0; chroma_strobe = 1'b0;
            @(negedge clk);
        end
        luma_ack = 1'b1; chroma_ack = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick_expect(input logic exp_valid, input logic [15:0] exp_word, input string req);
        pix_tick = 1'b1;
        @(negedge clk);
        pix_tick = 1'b0;
        check(pix_valid == exp_valid, req, {15'd0, pix_valid}, {15'd0, exp_valid});
        check(pix_word == exp_word, req, pix_word, exp_word);
        @(negedge clk);
        check(pix_valid == 1'b0, req, {15'd0, pix_valid}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 / R9: outputs idle during reset
        check(pix_word == 16'h0 && !pix_valid && !underrun, "R1", pix_word, 16'h0);
        rst = 1'b0;
        luma_ack = 1'b1; chroma_ack = 1'b1;
        @(negedge clk);
        check(pix_word == 16'h0 && !pix_valid && !underrun, "R1", {14'd0, pix_valid, underrun}, 16'h0);

        // R2 R3 R7: sweep all luma values, chroma derived arithmetically
        for (int y = 0; y < 256; y++) begin
            logic [7:0] c;
            c = 8'((y * 7 + 3) ^ 8'hA5);
            send(8'(y), c, 1'b1, 1'b1, 1'b1);
            tick_expect(1'b1, {8'(y), c}, "R2/R3/R7 sweep");
            last_word = {8'(y), c};
        end
        check(underrun == 1'b0, "R8 no underrun while fed", {15'd0, underrun}, 16'd0);

        // R4: strobes while ack low capture nothing
        send(8'h12, 8'h34, 1'b1, 1'b1, 1'b0);
        tick_expect(1'b0, last_word, "R4 ack low ignored");
        check(underrun == 1'b1, "R8 underrun raised", {15'd0, underrun}, 16'd1);

        // R5: upper nibble, ack drop, then a full byte
        luma_nib = 4'hF; chroma_nib = 4'hE; luma_strobe = 1'b1; chroma_strobe = 1'b1;
        @(negedge clk);
        luma_strobe = 1'b0; chroma_strobe = 1'b0;
        @(negedge clk);
        luma_ack = 1'b0; chroma_ack = 1'b0;
        @(negedge clk);
        luma_ack = 1'b1; chroma_ack = 1'b1;
        @(negedge clk);
        send(8'h6C, 8'h93, 1'b1, 1'b1, 1'b1);
        tick_expect(1'b1, 16'h6C93, "R5 partial discarded");
        last_word = 16'h6C93;

        // R6: luma alone, tick, then chroma alone
        send(8'hB7, 8'h00, 1'b1, 1'b0, 1'b1);
        tick_expect(1'b0, last_word, "R6 one lane only");
        send(8'h00, 8'h4D, 1'b0, 1'b1, 1'b1);
        tick_expect(1'b1, 16'hB74D, "R6 paired with parked byte");
        last_word = 16'hB74D;

        // R8: repeat on empty tick, flag stays up after good pixel
        tick_expect(1'b0, last_word, "R8 repeat word");
        send(8'h21, 8'h43, 1'b1, 1'b1, 1'b1);
        tick_expect(1'b1, 16'h2143, "R8 delivery after underrun");
        check(underrun == 1'b1, "R8 sticky", {15'd0, underrun}, 16'd1);

        // R9: reset mid-byte clears phases, stages and underrun
        luma_nib = 4'h9; chroma_nib = 4'h9; luma_strobe = 1'b1; chroma_strobe = 1'b1;
        @(negedge clk);
        luma_strobe = 1'b0; chroma_strobe = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pix_word == 16'h0 && !pix_valid && !underrun, "R9 cleared", {14'd0, pix_valid, underrun}, 16'h0);
        send(8'h5A, 8'hC3, 1'b1, 1'b1, 1'b1);
        tick_expect(1'b1, 16'h5AC3, "R9 phase reset");
        check(underrun == 1'b0, "R9 underrun cleared", {15'd0, underrun}, 16'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule